// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Execution Pipe

This block is the multiply side of a 32-bit integer core's execute stage. It has three multiply stages followed by a writeback stage. Some operations stay in the first stage for several cycles and reuse a 33x17 array once per pass. The number of passes is set by the operation class. A 32-bit product takes two passes. A 64-bit product, or a 64-bit accumulate, takes three. Half-word forms take one pass. While an operation loops in stage one, the pipe closes its issue handshake.

Decode hands over an opcode, two operands, a 64-bit accumulator split into two words, and a flag-update request, using a valid/ready pair. Results come back as a low word and a high word, each with its own strobe. A 64-bit result returns its low word one cycle before its high word. When flag update was requested, a negative flag and a zero flag return with the last strobe of that result.

Top module: `mac_iter_pipe`

## Requirements
- R1: While reset is held and on the first cycle after it, `ready_o` is 1 and `res_lo_valid_o`, `res_hi_valid_o` and `flags_valid_o` are all 0.
- R2: Opcode 0 returns bits 31:0 of a*b. Opcode 1 returns bits 31:0 of a*b+acc_lo. If the operation is accepted on rising edge k, `res_lo_valid_o` is high only in the cycle after edge k+4, and no high-word strobe follows.
- R3: Opcodes 2 and 3 return the unsigned and the signed 64-bit product. Opcodes 4 and 5 return the unsigned and the signed product plus {acc_hi,acc_lo}. The low word is strobed after edge k+5 and the high word after edge k+6.
- R4: The single-pass half-word forms use sign-extended 16-bit halves, with ll = a[15:0]*b[15:0] and hh = a[31:16]*b[31:16]. Opcode 6 returns ll. Opcode 7 returns ll+acc_lo. Opcode 8 returns ll+hh+acc_lo. Opcode 9 returns ll-hh+acc_lo. The 32-bit result is strobed after edge k+3.
- R5: Opcode 10 returns the 64-bit value ll+{acc_hi,acc_lo}, taking two passes. The low word is strobed after edge k+4 and the high word after edge k+5.
- R6: Opcode 11 returns bits 63:32 of the signed product a*b. Opcode 12 first adds 0x8000_0000 to that 64-bit product and then returns bits 63:32. The result is strobed after edge k+4.
- R7: With `setf_i` set, `flags_valid_o` goes high together with the final strobe of the result. `flag_n_o` is then bit 31 of the returned word, or bit 63 for a 64-bit result. `flag_z_o` is set when that whole result is zero. With `setf_i` clear, `flags_valid_o` stays low.
- R8: After a multi-pass operation is accepted, `ready_o` is low until that operation is in its last pass. `ready_o` also stays low during the last pass of any two-word operation. While `ready_o` is low, `valid_i` and the operand inputs have no effect.
- R9: Single-pass operations can be accepted on consecutive cycles, and their results come back in issue order on consecutive cycles. The low-word strobe and the high-word strobe are never high in the same cycle.
- R10: Results come back in issue order, each at the latency that its opcode fixes. Opcodes 13 to 15 are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue request |
| ready_o | output | 1 | Pipe can accept an operation |
| op_i | input | 4 | Opcode (see R2 to R6) |
| setf_i | input | 1 | Request update of N and Z |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_lo_i | input | 32 | Accumulator low word |
| acc_hi_i | input | 32 | Accumulator high word |
| res_lo_o | output | 32 | Result word (low, or upper for opcodes 11/12) |
| res_lo_valid_o | output | 1 | Low-word strobe |
| res_hi_o | output | 32 | High word of a 64-bit result |
| res_hi_valid_o | output | 1 | High-word strobe |
| flags_valid_o | output | 1 | Flag strobe |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
A wrong pass counter or a wrong recirculation decision in stage one shows up at the ports in two ways. The result strobe moves by a whole cycle, and `ready_o` reopens at the wrong time. Both are visible within five cycles of issue. A partial-product or sign-extension fault changes the returned words for only some operand patterns, so the directed cases include extreme negative and all-ones operands. A writeback hazard error shows as a low strobe that lands together with the previous operation's high strobe, or as a high word that is missing.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned XW = 32;
  localparam int unsigned HW = XW / 2;
  localparam int unsigned DW = 2 * XW;
  localparam int unsigned PW = XW + HW + 2;

  typedef enum logic [3:0] {
    OP_MUL   = 4'd0,
    OP_MLA   = 4'd1,
    OP_UMULL = 4'd2,
    OP_SMULL = 4'd3,
    OP_UMLAL = 4'd4,
    OP_SMLAL = 4'd5,
    OP_H16   = 4'd6,
    OP_H16A  = 4'd7,
    OP_DADD  = 4'd8,
    OP_DSUB  = 4'd9,
    OP_HL64  = 4'd10,
    OP_MSW   = 4'd11,
    OP_MSWR  = 4'd12
  } mac_op_e;

  // index of the final pass in stage one
  function automatic logic [1:0] op_last_pass(mac_op_e op);
    case (op)
      OP_UMULL, OP_SMULL, OP_UMLAL, OP_SMLAL: return 2'd2;
      OP_MUL, OP_MLA, OP_HL64, OP_MSW, OP_MSWR: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic op_dual_wb(mac_op_e op);
    return op inside {OP_UMULL, OP_SMULL, OP_UMLAL, OP_SMLAL, OP_HL64};
  endfunction

  function automatic logic op_signed(mac_op_e op);
    return op inside {OP_SMULL, OP_SMLAL, OP_MSW, OP_MSWR};
  endfunction

  function automatic logic op_uses_acc(mac_op_e op);
    return op inside {OP_MLA, OP_UMLAL, OP_SMLAL, OP_H16A, OP_DADD, OP_DSUB, OP_HL64};
  endfunction

  function automatic logic op_acc_word(mac_op_e op);
    return op inside {OP_MLA, OP_H16A, OP_DADD, OP_DSUB};
  endfunction

  function automatic logic op_upper(mac_op_e op);
    return op inside {OP_MSW, OP_MSWR};
  endfunction
endpackage

// File: rtl/mac_array_stage.sv
module mac_array_stage
  import mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  mac_op_e       op_i,
  input  logic          setf_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  input  logic [DW-1:0] acc_i,
  output logic          ready_o,
  output logic          out_vld_o,
  output mac_op_e       out_op_o,
  output logic          out_setf_o,
  output logic [DW-1:0] out_val_o,
  output logic [XW-1:0] out_acc_o
);
  logic          vld_q, setf_q;
  mac_op_e       op_q;
  logic [XW-1:0] a_q, b_q;
  logic [DW-1:0] accop_q, sum_q, sum_d;
  logic [1:0]    pass_q;
  logic          last;

  logic                 sgn;
  logic [XW:0]          a_ext;
  logic [HW:0]          chunk;
  logic signed [PW-1:0] prod;
  logic signed [XW-1:0] p_ll, p_hh;
  logic [DW-1:0]        prod_x, ll_x, hh_x;

  assign last    = pass_q == op_last_pass(op_q);
  assign ready_o = !vld_q || (last && !op_dual_wb(op_q));

  always_comb begin
    sgn    = op_signed(op_q);
    a_ext  = {sgn & a_q[XW-1], a_q};
    chunk  = (pass_q == 2'd0) ? {1'b0, b_q[HW-1:0]} : {sgn & b_q[XW-1], b_q[XW-1:HW]};
    prod   = $signed(a_ext) * $signed(chunk);
    prod_x = {{(DW-PW){prod[PW-1]}}, prod};
    p_ll   = $signed(a_q[HW-1:0]) * $signed(b_q[HW-1:0]);
    p_hh   = $signed(a_q[XW-1:HW]) * $signed(b_q[XW-1:HW]);
    ll_x   = {{(DW-XW){p_ll[XW-1]}}, p_ll};
    hh_x   = {{(DW-XW){p_hh[XW-1]}}, p_hh};
    case (op_q)
      OP_H16, OP_H16A: sum_d = ll_x;
      OP_DADD:         sum_d = ll_x + hh_x;
      OP_DSUB:         sum_d = ll_x - hh_x;
      OP_HL64:         sum_d = (pass_q == 2'd0) ? ll_x : sum_q + accop_q;
      default: begin
        // pass 0: low chunk, pass 1: high chunk, pass 2: 64-bit accumulate
        case (pass_q)
          2'd0:    sum_d = prod_x;
          2'd1:    sum_d = sum_q + (prod_x << HW);
          default: sum_d = sum_q + accop_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      setf_q  <= 1'b0;
      op_q    <= OP_MUL;
      a_q     <= '0;
      b_q     <= '0;
      accop_q <= '0;
      pass_q  <= '0;
      sum_q   <= '0;
    end else begin
      if (issue_i) begin
        vld_q   <= 1'b1;
        setf_q  <= setf_i;
        op_q    <= op_i;
        a_q     <= a_i;
        b_q     <= b_i;
        accop_q <= op_uses_acc(op_i) ? acc_i : '0;
        pass_q  <= '0;
      end else if (vld_q && last) begin
        vld_q <= 1'b0;
      end else if (vld_q) begin
        pass_q <= pass_q + 2'd1;
      end
      if (vld_q) sum_q <= sum_d;
    end
  end

  assign out_vld_o  = vld_q && last;
  assign out_op_o   = op_q;
  assign out_setf_o = setf_q;
  assign out_val_o  = sum_d;
  assign out_acc_o  = accop_q[XW-1:0];

  a_r8_recirc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !last |=> vld_q && (op_q == $past(op_q)) && (pass_q == $past(pass_q) + 2'd1));
  a_r8_busy_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && (op_last_pass(op_i) != 2'd0 || op_dual_wb(op_i)) |=> !ready_o);
  a_r2_pass_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> pass_q <= op_last_pass(op_q));
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  mac_op_e       in_op_i,
  input  logic          in_setf_i,
  input  logic [DW-1:0] in_val_i,
  input  logic [XW-1:0] in_acc_i,
  output logic          vld_o,
  output mac_op_e       op_o,
  output logic          setf_o,
  output logic [DW-1:0] val_o
);
  localparam logic [DW-1:0] RoundBit = {{XW{1'b0}}, 1'b1, {(XW-1){1'b0}}};

  logic [DW-1:0] addend;

  always_comb begin
    if (op_acc_word(in_op_i))   addend = {{XW{1'b0}}, in_acc_i};
    else if (in_op_i == OP_MSWR) addend = RoundBit;
    else                         addend = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= OP_MUL;
      setf_o <= 1'b0;
      val_o  <= '0;
    end else begin
      vld_o <= in_vld_i;
      if (in_vld_i) begin
        op_o   <= in_op_i;
        setf_o <= in_setf_i;
        val_o  <= in_val_i + addend;
      end
    end
  end
endmodule

// File: rtl/mac_fmt_stage.sv
module mac_fmt_stage
  import mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  mac_op_e       in_op_i,
  input  logic          in_setf_i,
  input  logic [DW-1:0] in_val_i,
  output logic          vld_o,
  output logic          setf_o,
  output logic          dual_o,
  output logic [XW-1:0] lo_o,
  output logic [XW-1:0] hi_o,
  output logic          n_o,
  output logic          z_o
);
  logic [XW-1:0] word;
  logic          dual, n_d, z_d;

  always_comb begin
    dual = op_dual_wb(in_op_i);
    word = op_upper(in_op_i) ? in_val_i[DW-1:XW] : in_val_i[XW-1:0];
    n_d  = dual ? in_val_i[DW-1] : word[XW-1];
    z_d  = dual ? (in_val_i == '0) : (word == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      setf_o <= 1'b0;
      dual_o <= 1'b0;
      lo_o   <= '0;
      hi_o   <= '0;
      n_o    <= 1'b0;
      z_o    <= 1'b0;
    end else begin
      vld_o <= in_vld_i;
      if (in_vld_i) begin
        setf_o <= in_setf_i;
        dual_o <= dual;
        lo_o   <= word;
        hi_o   <= in_val_i[DW-1:XW];
        n_o    <= n_d;
        z_o    <= z_d;
      end
    end
  end
endmodule

// File: rtl/mac_wb_stage.sv
module mac_wb_stage
  import mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  logic          in_setf_i,
  input  logic          in_dual_i,
  input  logic [XW-1:0] in_lo_i,
  input  logic [XW-1:0] in_hi_i,
  input  logic          in_n_i,
  input  logic          in_z_i,
  output logic          lo_vld_o,
  output logic [XW-1:0] lo_o,
  output logic          hi_vld_o,
  output logic [XW-1:0] hi_o,
  output logic          flag_vld_o,
  output logic          flag_n_o,
  output logic          flag_z_o
);
  logic          pend_vld_q, pend_setf_q, pend_n_q, pend_z_q;
  logic [XW-1:0] pend_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_vld_o    <= 1'b0;
      lo_o        <= '0;
      hi_vld_o    <= 1'b0;
      hi_o        <= '0;
      pend_vld_q  <= 1'b0;
      pend_setf_q <= 1'b0;
      pend_n_q    <= 1'b0;
      pend_z_q    <= 1'b0;
      pend_hi_q   <= '0;
      flag_vld_o  <= 1'b0;
      flag_n_o    <= 1'b0;
      flag_z_o    <= 1'b0;
    end else begin
      lo_vld_o <= in_vld_i;
      if (in_vld_i) lo_o <= in_lo_i;
      // high word holds one cycle behind the low word
      pend_vld_q <= in_vld_i && in_dual_i;
      if (in_vld_i && in_dual_i) begin
        pend_hi_q   <= in_hi_i;
        pend_setf_q <= in_setf_i;
        pend_n_q    <= in_n_i;
        pend_z_q    <= in_z_i;
      end
      hi_vld_o <= pend_vld_q;
      if (pend_vld_q) hi_o <= pend_hi_q;
      if (pend_vld_q) begin
        flag_vld_o <= pend_setf_q;
        flag_n_o   <= pend_n_q;
        flag_z_o   <= pend_z_q;
      end else if (in_vld_i && !in_dual_i) begin
        flag_vld_o <= in_setf_i;
        flag_n_o   <= in_n_i;
        flag_z_o   <= in_z_i;
      end else begin
        flag_vld_o <= 1'b0;
      end
    end
  end

  a_r9_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_vld_o && hi_vld_o));
  a_r3_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_vld_o |-> $past(lo_vld_o));
  a_r9_hi_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_vld_o |=> !hi_vld_o);
  a_r7_flags_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_vld_o |-> (lo_vld_o || hi_vld_o));
endmodule

// File: rtl/mac_iter_pipe.sv
module mac_iter_pipe
  import mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic [3:0]    op_i,
  input  logic          setf_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  input  logic [XW-1:0] acc_lo_i,
  input  logic [XW-1:0] acc_hi_i,
  output logic [XW-1:0] res_lo_o,
  output logic          res_lo_valid_o,
  output logic [XW-1:0] res_hi_o,
  output logic          res_hi_valid_o,
  output logic          flags_valid_o,
  output logic          flag_n_o,
  output logic          flag_z_o
);
  logic          issue;
  logic          s1_vld, s1_setf;
  mac_op_e       s1_op;
  logic [DW-1:0] s1_val;
  logic [XW-1:0] s1_acc;
  logic          s2_vld, s2_setf;
  mac_op_e       s2_op;
  logic [DW-1:0] s2_val;
  logic          s3_vld, s3_setf, s3_dual, s3_n, s3_z;
  logic [XW-1:0] s3_lo, s3_hi;

  assign issue = valid_i && ready_o;

  mac_array_stage u_mac1 (
    .clk_i, .rst_ni,
    .issue_i    (issue),
    .op_i       (mac_op_e'(op_i)),
    .setf_i,
    .a_i,
    .b_i,
    .acc_i      ({acc_hi_i, acc_lo_i}),
    .ready_o,
    .out_vld_o  (s1_vld),
    .out_op_o   (s1_op),
    .out_setf_o (s1_setf),
    .out_val_o  (s1_val),
    .out_acc_o  (s1_acc)
  );

  mac_acc_stage u_mac2 (
    .clk_i, .rst_ni,
    .in_vld_i  (s1_vld),
    .in_op_i   (s1_op),
    .in_setf_i (s1_setf),
    .in_val_i  (s1_val),
    .in_acc_i  (s1_acc),
    .vld_o     (s2_vld),
    .op_o      (s2_op),
    .setf_o    (s2_setf),
    .val_o     (s2_val)
  );

  mac_fmt_stage u_mac3 (
    .clk_i, .rst_ni,
    .in_vld_i  (s2_vld),
    .in_op_i   (s2_op),
    .in_setf_i (s2_setf),
    .in_val_i  (s2_val),
    .vld_o     (s3_vld),
    .setf_o    (s3_setf),
    .dual_o    (s3_dual),
    .lo_o      (s3_lo),
    .hi_o      (s3_hi),
    .n_o       (s3_n),
    .z_o       (s3_z)
  );

  mac_wb_stage u_wb (
    .clk_i, .rst_ni,
    .in_vld_i   (s3_vld),
    .in_setf_i  (s3_setf),
    .in_dual_i  (s3_dual),
    .in_lo_i    (s3_lo),
    .in_hi_i    (s3_hi),
    .in_n_i     (s3_n),
    .in_z_i     (s3_z),
    .lo_vld_o   (res_lo_valid_o),
    .lo_o       (res_lo_o),
    .hi_vld_o   (res_hi_valid_o),
    .hi_o       (res_hi_o),
    .flag_vld_o (flags_valid_o),
    .flag_n_o,
    .flag_z_o
  );

  a_r10_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld |=> s3_vld);
endmodule

// File: tb/mac_iter_pipe_tb.sv
module mac_iter_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [3:0]  op_i = '0;
  logic        setf_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
  logic [31:0] res_lo_o, res_hi_o;
  logic        res_lo_valid_o, res_hi_valid_o, flags_valid_o, flag_n_o, flag_z_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int          op_q[8];
  logic [31:0] a_q[8], b_q[8];
  logic [63:0] acc_q[8];
  bit          sf_q[8];
  string       tag_q[8];
  int          issue_c[8];

  always #10 clk = ~clk;

  mac_iter_pipe u_dut (
    .clk_i(clk), .rst_ni, .valid_i, .ready_o, .op_i, .setf_i, .a_i, .b_i,
    .acc_lo_i, .acc_hi_i, .res_lo_o, .res_lo_valid_o, .res_hi_o, .res_hi_valid_o,
    .flags_valid_o, .flag_n_o, .flag_z_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_res(input int op, input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
    logic [63:0] ua, ub, sa, sb, ll, hh, al;
    ua = {32'h0, a};
    ub = {32'h0, b};
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ll = {{48{a[15]}}, a[15:0]} * {{48{b[15]}}, b[15:0]};
    hh = {{48{a[31]}}, a[31:16]} * {{48{b[31]}}, b[31:16]};
    al = {32'h0, acc[31:0]};
    case (op)
      0, 2:    return ua * ub;
      1:       return ua * ub + al;
      3, 11:   return sa * sb;
      4:       return ua * ub + acc;
      5:       return sa * sb + acc;
      6:       return ll;
      7:       return ll + al;
      8:       return ll + hh + al;
      9:       return ll - hh + al;
      10:      return ll + acc;
      12:      return sa * sb + 64'h8000_0000;
      default: return 64'h0;
    endcase
  endfunction

  function automatic int lat_of(input int op);
    if (op >= 2 && op <= 5) return 5;
    if (op >= 6 && op <= 9) return 3;
    return 4;
  endfunction

  function automatic bit dual_of(input int op);
    return (op >= 2 && op <= 5) || op == 10;
  endfunction

  task automatic set_op(input int i, input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] acc, input bit sf, input string tag);
    op_q[i] = op; a_q[i] = a; b_q[i] = b; acc_q[i] = acc; sf_q[i] = sf; tag_q[i] = tag;
  endtask

  // issues ops 0..n-1 as fast as ready_o allows and checks every strobe
  task automatic run_ops(input int n);
    int nxt = 0, lo_i = 0, hi_k = -1, hi_due = 0;
    logic [63:0] r;
    logic [31:0] w;
    for (int c = 0; c < n * 8 + 12; c++) begin
      @(negedge clk);
      if (res_lo_valid_o) begin
        if (lo_i >= n) chk(1'b0, "R10 unexpected low strobe", 64'(res_lo_o), 64'h0);
        else begin
          r = ref_res(op_q[lo_i], a_q[lo_i], b_q[lo_i], acc_q[lo_i]);
          w = (op_q[lo_i] >= 11) ? r[63:32] : r[31:0];
          chk(c == issue_c[lo_i] + lat_of(op_q[lo_i]) + 1, {tag_q[lo_i], " low strobe cycle"},
              64'(c - issue_c[lo_i] - 1), 64'(lat_of(op_q[lo_i])));
          chk(res_lo_o == w, {tag_q[lo_i], " low word"}, 64'(res_lo_o), 64'(w));
          if (dual_of(op_q[lo_i])) begin
            hi_k = lo_i; hi_due = c + 1;
          end else if (sf_q[lo_i]) begin
            chk(flags_valid_o && flag_n_o == w[31] && flag_z_o == (w == 0), {tag_q[lo_i], " R7 flags"},
                {61'h0, flags_valid_o, flag_n_o, flag_z_o}, {61'h0, 1'b1, w[31], w == 0});
          end else begin
            chk(!flags_valid_o, {tag_q[lo_i], " R7 no flags"}, 64'(flags_valid_o), 64'h0);
          end
          lo_i++;
        end
      end
      if (res_hi_valid_o) begin
        if (hi_k < 0 || c != hi_due) chk(1'b0, "R9 stray high strobe", 64'(c), 64'(hi_due));
        else begin
          r = ref_res(op_q[hi_k], a_q[hi_k], b_q[hi_k], acc_q[hi_k]);
          chk(res_hi_o == r[63:32], {tag_q[hi_k], " high word"}, 64'(res_hi_o), 64'(r[63:32]));
          if (sf_q[hi_k])
            chk(flags_valid_o && flag_n_o == r[63] && flag_z_o == (r == 0), {tag_q[hi_k], " R7 flags"},
                {61'h0, flags_valid_o, flag_n_o, flag_z_o}, {61'h0, 1'b1, r[63], r == 0});
          else
            chk(!flags_valid_o, {tag_q[hi_k], " R7 no flags"}, 64'(flags_valid_o), 64'h0);
          hi_k = -1;
        end
      end else if (hi_k >= 0 && c >= hi_due) begin
        chk(1'b0, {tag_q[hi_k], " missing high strobe"}, 64'h0, 64'h1);
        hi_k = -1;
      end
      if (nxt < n && ready_o) begin
        valid_i = 1'b1; op_i = 4'(op_q[nxt]); a_i = a_q[nxt]; b_i = b_q[nxt];
        acc_lo_i = acc_q[nxt][31:0]; acc_hi_i = acc_q[nxt][63:32]; setf_i = sf_q[nxt];
        issue_c[nxt] = c;
        nxt++;
      end else begin
        valid_i = 1'b0;
      end
    end
    chk(lo_i == n, "R10 result count", 64'(lo_i), 64'(n));
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk(ready_o && !res_lo_valid_o && !res_hi_valid_o && !flags_valid_o, "R1 during reset",
        {60'h0, ready_o, res_lo_valid_o, res_hi_valid_o, flags_valid_o}, 64'h8);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o && !res_lo_valid_o && !res_hi_valid_o && !flags_valid_o, "R1 after reset",
        {60'h0, ready_o, res_lo_valid_o, res_hi_valid_o, flags_valid_o}, 64'h8);
  endtask

  task automatic test_mul32;
    set_op(0, 0, 32'h1234_5678, 32'h9abc_def0, 64'h0, 0, "R2 mul");
    set_op(1, 1, 32'hffff_ffff, 32'hffff_ffff, 64'h5, 0, "R2 mla ones");
    set_op(2, 0, 32'h8000_0000, 32'h0000_0002, 64'h0, 0, "R2 mul wrap");
    set_op(3, 1, 32'hffff_fffd, 32'h0000_0007, 64'h0000_0000_0000_0100, 0, "R2 mla neg");
    run_ops(4);
  endtask

  task automatic test_long;
    set_op(0, 2, 32'hffff_ffff, 32'hffff_ffff, 64'h0, 0, "R3 umull max");
    set_op(1, 3, 32'h8000_0000, 32'h7fff_ffff, 64'h0, 0, "R3 smull");
    set_op(2, 4, 32'hffff_ffff, 32'h0000_0003, 64'hffff_ffff_ffff_ffff, 0, "R3 umlal");
    set_op(3, 5, 32'hffff_fffd, 32'h0000_0005, 64'h0000_0001_0000_0000, 0, "R3 smlal");
    run_ops(4);
  endtask

  task automatic test_half;
    set_op(0, 6, 32'h1234_8000, 32'hffff_7fff, 64'h0, 0, "R4 h16");
    set_op(1, 7, 32'h0000_fffe, 32'h0000_0003, 64'h64, 0, "R4 h16 acc");
    set_op(2, 8, 32'h7fff_7fff, 32'h7fff_7fff, 64'h0, 0, "R4 dual add");
    set_op(3, 9, 32'h0002_0003, 32'h8000_0004, 64'h7, 0, "R4 dual sub");
    run_ops(4);
  endtask

  task automatic test_hl64;
    set_op(0, 10, 32'h0000_ffff, 32'h0000_0002, 64'h0000_0001_0000_0000, 0, "R5 half long acc");
    set_op(1, 10, 32'h0000_8000, 32'h0000_8000, 64'hffff_ffff_ffff_ffff, 0, "R5 half long max");
    run_ops(2);
  endtask

  task automatic test_msw;
    set_op(0, 11, 32'h4000_0000, 32'h4000_0000, 64'h0, 0, "R6 msw");
    set_op(1, 11, 32'h0001_0000, 32'h0000_8000, 64'h0, 0, "R6 msw trunc");
    set_op(2, 12, 32'h0001_0000, 32'h0000_8000, 64'h0, 0, "R6 msw round up");
    set_op(3, 12, 32'hffff_ffff, 32'h7fff_ffff, 64'h0, 0, "R6 msw round neg");
    run_ops(4);
  endtask

  task automatic test_flags;
    set_op(0, 0, 32'h0001_0000, 32'h0001_0000, 64'h0, 1, "R7 zero word");
    set_op(1, 3, 32'hffff_ffff, 32'h0000_0001, 64'h0, 1, "R7 neg long");
    set_op(2, 2, 32'h0000_0000, 32'h0000_0005, 64'h0, 1, "R7 zero long");
    set_op(3, 0, 32'hffff_ffff, 32'h0000_0002, 64'h0, 0, "R7 no request");
    set_op(4, 6, 32'h0000_8000, 32'h0000_0001, 64'h0, 1, "R7 neg half");
    run_ops(5);
  endtask

  task automatic test_ready;
    int seen;
    logic [63:0] r;
    @(negedge clk);
    chk(ready_o, "R8 idle ready", 64'(ready_o), 64'h1);
    valid_i = 1'b1; op_i = 4'd2; a_i = 32'hdead_beef; b_i = 32'h0000_1001; setf_i = 1'b0;
    acc_lo_i = '0; acc_hi_i = '0;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(!ready_o, "R8 ready low during long op", 64'(ready_o), 64'h0);
      op_i = 4'd6; a_i = 32'h0000_0005; b_i = 32'h0000_0005;  // must be ignored
    end
    valid_i = 1'b0;
    @(negedge clk);
    chk(ready_o, "R8 ready back after long op", 64'(ready_o), 64'h1);
    r = ref_res(2, 32'hdead_beef, 32'h0000_1001, 64'h0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (res_lo_valid_o) begin
        seen++;
        chk(res_lo_o == r[31:0], "R8 only accepted op returns", 64'(res_lo_o), 64'(r[31:0]));
      end
    end
    chk(seen == 1, "R8 ignored issue count", 64'(seen), 64'h1);

    valid_i = 1'b1; op_i = 4'd0;
    @(negedge clk);
    valid_i = 1'b0;
    chk(!ready_o, "R8 two-pass first cycle", 64'(ready_o), 64'h0);
    @(negedge clk);
    chk(ready_o, "R8 two-pass last pass", 64'(ready_o), 64'h1);
    repeat (6) @(negedge clk);
    valid_i = 1'b1; op_i = 4'd6;
    @(negedge clk);
    valid_i = 1'b0;
    chk(ready_o, "R8 single pass keeps ready", 64'(ready_o), 64'h1);
    repeat (6) @(negedge clk);
  endtask

  task automatic test_stream;
    set_op(0, 6, 32'h0000_0003, 32'h0000_0004, 64'h0, 0, "R9 stream a");
    set_op(1, 6, 32'h0000_ffff, 32'h0000_0009, 64'h0, 0, "R9 stream b");
    set_op(2, 8, 32'h0010_0020, 32'h0030_0040, 64'h0, 1, "R9 stream c");
    set_op(3, 9, 32'h0001_0001, 32'h0002_0002, 64'h0, 0, "R9 stream d");
    set_op(4, 10, 32'h0000_0007, 32'h0000_fff0, 64'h10, 1, "R9 half long");
    set_op(5, 6, 32'h0000_0011, 32'h0000_0002, 64'h0, 0, "R9 follower");
    set_op(6, 1, 32'h0000_0100, 32'h0000_0100, 64'h1, 0, "R10 after follower");
    run_ops(7);
    for (int i = 1; i < 4; i++)
      chk(issue_c[i] - issue_c[i-1] == 1, "R9 back-to-back issue", 64'(issue_c[i] - issue_c[i-1]), 64'h1);
    chk(issue_c[5] - issue_c[4] == 3, "R9 gap after two-word op", 64'(issue_c[5] - issue_c[4]), 64'h3);
  endtask

  initial begin
    test_reset();
    test_mul32();
    test_long();
    test_half();
    test_hl64();
    test_msw();
    test_flags();
    test_ready();
    test_stream();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule